// File: doc/BRIEF.md
# Sign-Magnitude Stochastic Bitstream Generator

This block turns a signed binary operand into a stochastic number in sign-magnitude form. It emits the operand's sign once per conversion period. The magnitude travels as a serial bitstream whose count of ones over one period equals the absolute value of the operand. A comparator tests the lower operand bits against a pseudo-random value that sweeps every code once per period. A single XOR with the operand's top bit then flips the comparison result for negative operands. This gives the two's-complement magnitude without an adder or a per-bit negation.

A user holds `en` high to advance the stream one bit per cycle. The operand on `din` is captured only on the first step of each period, and `first_o` marks the bit that opens a period. `restart` realigns the random source to its seed and starts a fresh period, so a given operand always yields the same bit pattern after a restart.

Top module: `smsng_top`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `valid_o`, `first_o`, `sign_o` and `bit_o` are all 0.
- R2: `sign_o` equals bit N-1 (the MSB) of the operand captured for the current period, and it keeps that value on every valid bit of the period.
- R3: For an operand with MSB 0, the number of 1s on `bit_o` over the 2^(N-1) valid bits of one period equals the operand's value.
- R4: For an operand with MSB 1, the number of 1s over one period equals the operand's magnitude 2^N minus its unsigned code. The most negative code gives 2^(N-1) ones, which is every bit.
- R5: `din` is sampled only on the enabled step that opens a period. Changing it on any other cycle has no effect on that period's sign or count.
- R6: A period is exactly 2^(N-1) enabled steps. The output bit of an enabled step appears one cycle later with `valid_o` = 1, and `first_o` = 1 exactly on the first bit of each period.
- R7: A cycle with `en` low emits no bit (`valid_o` = 0 one cycle later) and freezes the random source and the phase. A period interrupted by such gaps still has the exact count of R3 and R4.
- R8: `restart` discards the current period. On the next cycle `valid_o` is 0, the random source is back at its seed, and the next enabled step opens a new period with a new capture.
- R9: The random source visits every (N-1)-bit code, including zero, once per period. After a restart, the same operand therefore reproduces the identical bit sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Reload random seed and begin a new period |
| en | input | 1 | Advance the stream by one bit this cycle |
| din | input | N | Signed two's-complement operand |
| valid_o | output | 1 | A bit is present on `bit_o` |
| first_o | output | 1 | This bit opens a period |
| sign_o | output | 1 | Sign of the operand being converted |
| bit_o | output | 1 | Magnitude stream bit |

## Verification
Every result leaves through one register stage, so an enabled step at one rising edge shows its bit, sign and flags after that edge. The scoreboard monitor samples on the following falling edge. The driver queues an expected item (sign and ones count) when it starts a period. The monitor pops that item only after it has counted exactly 2^(N-1) valid bits, so every count is judged over a complete period rather than at a fixed cycle. Checks on idle cycles and on restart look at `valid_o` at the falling edge one cycle after the stimulus edge.

// File: rtl/smsng_pkg.sv
package smsng_pkg;

  // Feedback tap mask (bit k set means state bit k feeds back) for a
  // maximal-length shift register of the given width.
  function automatic logic [15:0] tap_mask(input int width);
    logic [15:0] m;
    m = '0;
    case (width)
      2:  m = 16'h0003;
      3:  m = 16'h0006;
      4:  m = 16'h000C;
      5:  m = 16'h0014;
      6:  m = 16'h0030;
      7:  m = 16'h0060;
      8:  m = 16'h00B8;
      9:  m = 16'h0110;
      10: m = 16'h0240;
      11: m = 16'h0500;
      12: m = 16'h0829;
      13: m = 16'h100D;
      14: m = 16'h2015;
      15: m = 16'h6000;
      default: m = 16'hD008;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/smsng_rng.sv
module smsng_rng #(
  parameter int W    = 7,
  parameter int SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         step,
  output logic [W-1:0] state
);
  import smsng_pkg::*;

  localparam logic [15:0]  TAPS     = tap_mask(W);
  localparam logic [W-1:0] SEED_VAL = W'(SEED);
  localparam logic [W-1:0] TOP_CODE = {1'b1, {(W-1){1'b0}}};

  logic lin_fb;
  logic low_zero;
  logic fb;

  always_comb begin
    lin_fb   = ^(state & TAPS[W-1:0]);
    low_zero = (state[W-2:0] == '0);
    // Flipping the feedback when the surviving bits are zero
    // splices the all-zero code into the maximal cycle.
    fb       = lin_fb ^ low_zero;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state <= SEED_VAL;
    end else if (step) begin
      state <= {state[W-2:0], fb};
    end
  end

  a_r9_zero_after_top: assert property (@(posedge clk) disable iff (rst)
    (step && !restart && state == TOP_CODE) |=> state == '0);

  a_r9_one_after_zero: assert property (@(posedge clk) disable iff (rst)
    (step && !restart && state == '0) |=> state == W'(1));

  a_r8_seed_reload: assert property (@(posedge clk) disable iff (rst)
    restart |=> state == SEED_VAL);

endmodule

// File: rtl/smsng_cmp.sv
module smsng_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] low_bits,
  input  logic [W-1:0] rnd,
  input  logic         neg,
  output logic         bit_out
);
  logic above;

  always_comb begin
    above   = (low_bits > rnd);
    bit_out = above ^ neg;
  end

endmodule

// File: rtl/smsng_top.sv
module smsng_top #(
  parameter int N    = 8,
  parameter int SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         en,
  input  logic [N-1:0] din,
  output logic         valid_o,
  output logic         first_o,
  output logic         sign_o,
  output logic         bit_o
);
  localparam int M = N - 1;

  logic [M-1:0] phase;
  logic [N-1:0] held;
  logic [N-1:0] cur;
  logic [M-1:0] rnd;
  logic         boundary;
  logic         step;
  logic         cmp_bit;

  always_comb begin
    boundary = (phase == '0);
    cur      = boundary ? din : held;
    step     = en && !restart;
  end

  smsng_rng #(.W(M), .SEED(SEED)) u_rng (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .step    (step),
    .state   (rnd)
  );

  smsng_cmp #(.W(M)) u_cmp (
    .low_bits (cur[M-1:0]),
    .rnd      (rnd),
    .neg      (cur[N-1]),
    .bit_out  (cmp_bit)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase   <= '0;
      held    <= '0;
      valid_o <= 1'b0;
      first_o <= 1'b0;
      sign_o  <= 1'b0;
      bit_o   <= 1'b0;
    end else if (en) begin
      phase   <= phase + 1'b1;
      if (boundary) held <= din;
      valid_o <= 1'b1;
      first_o <= boundary;
      sign_o  <= cur[N-1];
      bit_o   <= cmp_bit;
    end else begin
      valid_o <= 1'b0;
    end
  end

  // Sign seen on the previous valid bit, for the steadiness check.
  logic sign_ref;
  always_ff @(posedge clk) begin
    if (rst) sign_ref <= 1'b0;
    else if (valid_o) sign_ref <= sign_o;
  end

  a_r2_sign_steady: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !first_o) |-> sign_o == sign_ref);

  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |=> !valid_o);

  a_r7_idle_no_bit: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid_o);

endmodule

// File: tb/sim_smsng_top.sv
module sim_smsng_top;
  localparam int N      = 8;
  localparam int M      = N - 1;
  localparam int PERIOD = 1 << M;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic en = 1'b0;
  logic [N-1:0] din = '0;
  logic valid_o, first_o, sign_o, bit_o;

  always #5 clk = ~clk;

  smsng_top #(.N(N), .SEED(1)) u0 (
    .clk(clk), .rst(rst), .restart(restart), .en(en), .din(din),
    .valid_o(valid_o), .first_o(first_o), .sign_o(sign_o), .bit_o(bit_o)
  );

  int checks = 0;
  int errors = 0;
  logic [N-1:0] expq[$];
  logic rec_a [PERIOD];
  logic rec_b [PERIOD];
  int rec_sel = -1;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: counts valid bits per period and compares with the queue.
  int  mcnt = 0;
  int  ones = 0;
  bit  sign0 = 1'b0;
  bit  sign_bad = 1'b0;
  bit  first_bad = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        if (mcnt == 0) begin
          ones = 0; sign0 = sign_o; sign_bad = 1'b0; first_bad = !first_o;
        end else begin
          if (first_o) first_bad = 1'b1;
          if (sign_o != sign0) sign_bad = 1'b1;
        end
        if (rec_sel == 0) rec_a[mcnt] = bit_o;
        if (rec_sel == 1) rec_b[mcnt] = bit_o;
        ones += int'(bit_o);
        mcnt++;
        if (mcnt == PERIOD) begin
          if (expq.size() == 0) begin
            check(1'b0, "R6", "period without expected item", 1, 0);
          end else begin
            logic [N-1:0] v;
            int mag;
            v = expq.pop_front();
            mag = v[N-1] ? (1 << N) - int'(v) : int'(v);
            check(!first_bad, "R6", "first_o placement", int'(first_bad), 0);
            check(sign0 == v[N-1] && !sign_bad, "R2", "sign",
                  int'(sign0) + 2 * int'(sign_bad), int'(v[N-1]));
            if (v[N-1]) check(ones == mag, "R4", "negative ones count", ones, mag);
            else        check(ones == mag, "R3", "non-negative ones count", ones, mag);
          end
          mcnt = 0;
        end
      end
      if (restart) mcnt = 0;
    end
  end

  // Driver: one full period of value v; din is scrambled after capture (R5).
  task automatic run_period(input logic [N-1:0] v, input bit gap);
    expq.push_back(v);
    for (int i = 0; i < PERIOD; i++) begin
      din = (i == 0) ? v : N'($urandom);
      en  = 1'b1;
      @(posedge clk); #1;
      if (gap && (i == PERIOD / 2 || i == 5)) begin
        en  = 1'b0;
        din = N'($urandom);
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(negedge clk);
        check(valid_o == 1'b0, "R7", "valid_o during idle", int'(valid_o), 0);
        #1;
      end
    end
  endtask

  task automatic pulse_restart();
    en = 1'b0;
    restart = 1'b1;
    @(posedge clk); #1;
    restart = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0, "R8", "valid_o after restart", int'(valid_o), 0);
    #1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({valid_o, first_o, sign_o, bit_o} == 4'b0, "R1", "outputs in reset",
          int'({valid_o, first_o, sign_o, bit_o}), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0, "R1", "valid_o after reset", int'(valid_o), 0);
    @(posedge clk); #1;

    // R3, R4, R5: every operand code, one period each.
    for (int v = 0; v < (1 << N); v++) run_period(N'(v), 1'b0);

    // R7: a negative operand with idle gaps inside the period.
    run_period(N'(-37), 1'b1);
    // R7: a positive operand with idle gaps.
    run_period(N'(90), 1'b1);

    // R8: abandon a period half way, then convert a fresh operand.
    for (int i = 0; i < 20; i++) begin
      din = N'(-100); en = 1'b1;
      @(posedge clk); #1;
    end
    pulse_restart();
    run_period(N'(5), 1'b0);

    // R9: same operand after two restarts gives the same stream.
    pulse_restart();
    rec_sel = 0;
    run_period(N'(37), 1'b0);
    pulse_restart();
    rec_sel = 1;
    run_period(N'(37), 1'b0);
    en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rec_sel = -1;
    begin
      int diff;
      diff = 0;
      for (int i = 0; i < PERIOD; i++) if (rec_a[i] !== rec_b[i]) diff++;
      check(diff == 0, "R9", "differing bits between repeated streams", diff, 0);
    end
    check(expq.size() == 0, "R6", "periods left unfinished", expq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule